// File: doc/BRIEF.md
# PRBS Hyperframe Pattern Checker (16-bit lane)

This block sits on the receive side of a serial link, after the byte-level decoding and alignment. The link carries a test pattern built from repeating hyperframes. Each hyperframe opens with one sync beat, a control character on the low byte. All the beats after it form a data block that follows a PRBS-7 sequence. The checker watches the 16-bit data lane and its two per-byte control flags, and it finds the hyperframe framing.

Once the framing is confirmed, the checker regenerates the PRBS sequence locally and compares it against every data beat. Mismatching beats are counted in a saturating 5-bit counter, and a sticky flag records that at least one error has occurred. A one-cycle stop pulse follows each sync character that lands on an expected boundary. This pulse is the receive-side timestamp for latency measurement.

The hyperframe length depends on a 4-bit rate select. A simulation-mode parameter shortens it to a quarter. The generator must use the same settings.

Top module: `hfPrbsChecker`

## Requirements
- R1: While `rstN` is low, `hfSync`, `errCount`, `errSticky` and `stopPulse` are all zero.
- R2: A beat is a sync character only when `rxCtrl[0]` is 1 and `rxData[7:0]` is 0xBC. The high byte and `rxCtrl[1]` are ignored, so 0xBC on the high byte with `rxCtrl[1]` set is not a sync character.
- R3: From the unsynchronised state, two sync characters exactly L beats apart raise `hfSync` in the cycle after the second one. A single sync character is not enough.
- R4: The hyperframe length is L = BASE_BEATS x max(rateSel, 1) beats, with a default BASE_BEATS of 32. When SIM_MODE is non-zero, L is a quarter of that. A second sync character at any other spacing does not give sync.
- R5: While in sync, one missing sync character at an expected boundary keeps `hfSync` high. Two consecutive missing sync characters drop it in the cycle after the second miss.
- R6: Data beat k of a hyperframe (k = 0 for the beat after the sync beat) carries PRBS-7 bits 16k to 16k+15 of the sequence x^7+x^6+1. The register is seeded to 0x7F, each new bit is state[6] xor state[5], and that bit is shifted in at the bottom. The first bit of each beat lands on bit 15. The sequence restarts at every hyperframe.
- R7: Data beats are compared only while `hfSync` is high. Before sync, a wrong data beat leaves `errCount` unchanged.
- R8: `errCount` rises by exactly 1 in the cycle after each mismatching data beat and saturates at 31.
- R9: `errSticky` is high exactly when `errCount` is non-zero, and it clears only on reset.
- R10: `stopPulse` is high for one cycle after each sync character that falls on an expected boundary. This covers the confirming sync character and every sync character seen while in sync.
- R11: Reset is asynchronous. Outputs clear as soon as `rstN` falls, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rateSel | input | 4 | Rate select that sets the hyperframe length |
| rxData | input | 16 | Received data lane |
| rxCtrl | input | 2 | Per-byte control flags (bit 0 for the low byte) |
| hfSync | output | 1 | Hyperframe sync achieved |
| errCount | output | 5 | Saturating count of mismatching data beats |
| errSticky | output | 1 | At least one mismatch since reset |
| stopPulse | output | 1 | One-cycle pulse after each confirmed boundary |

## Verification
The following checks run on every cycle:
- `hfSync` may rise only after a sync character.
- `hfSync` may fall only after a missing sync character.
- `stopPulse` always follows a sync character.
- The error count moves only in unit steps, holds at saturation, and never moves while comparison is off.
- The sticky flag tracks a non-zero count.

Only the bench scenarios can show some behaviours. These are:
- the exact spacing needed to lock at different rate selects and in simulation mode;
- the one-miss tolerance;
- the PRBS bit order;
- the rejection of a sync character on the wrong byte.

// File: rtl/hfChkPkg.sv
package hfChkPkg;

  localparam logic [7:0] SYNC_CHAR  = 8'hBC;
  localparam logic [6:0] PRBS_SEED  = 7'h7F;
  localparam int         MAX_RATE   = 15;

  // strobes from sync control to the datapath
  typedef struct packed {
    logic seedLoad;
    logic advance;
    logic checkEn;
  } dpStrobe_t;

  typedef enum logic [1:0] {
    ST_HUNT   = 2'd0,
    ST_VERIFY = 2'd1,
    ST_LOCKED = 2'd2
  } syncState_t;

  function automatic int unsigned frameBeats(input logic [3:0] rateSel,
                                             input int unsigned baseBeats,
                                             input bit simMode);
    int unsigned mult;
    int unsigned len;
    mult = 32'(rateSel);
    if (mult == 0) mult = 1;
    len = baseBeats * mult;
    if (simMode) len = len >> 2;
    return len;
  endfunction

endpackage

// File: rtl/hfSyncCtrl.sv
module hfSyncCtrl
  import hfChkPkg::*;
#(
  parameter int BASE_BEATS = 32,
  parameter int SIM_MODE   = 0,
  parameter int IDX_W      = 9
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [3:0] rateSel,
  input  logic [7:0] lowByte,
  input  logic       lowFlag,
  output dpStrobe_t  strobe,
  output logic       hfSync,
  output logic       stopPulse
);

  syncState_t       state, stateN;
  logic [IDX_W-1:0] nextIdx, idxN, lenM1;
  logic             missOnce, missN, stopN;
  logic             syncSeen, atBoundary;

  assign syncSeen   = lowFlag && (lowByte == SYNC_CHAR);
  assign lenM1      = IDX_W'(frameBeats(rateSel, BASE_BEATS, SIM_MODE != 0) - 1);
  assign atBoundary = (state != ST_HUNT) && (nextIdx == '0);

  always_comb begin
    stateN = state;
    missN  = missOnce;
    stopN  = 1'b0;
    idxN   = (nextIdx == lenM1) ? '0 : nextIdx + 1'b1;
    strobe = '0;
    case (state)
      ST_HUNT: begin
        idxN = IDX_W'(1);
        if (syncSeen) begin
          stateN          = ST_VERIFY;
          strobe.seedLoad = 1'b1;
        end
      end
      ST_VERIFY: begin
        if (atBoundary) begin
          if (syncSeen) begin
            stateN          = ST_LOCKED;
            missN           = 1'b0;
            stopN           = 1'b1;
            strobe.seedLoad = 1'b1;
          end else begin
            stateN = ST_HUNT;
          end
        end else begin
          strobe.advance = 1'b1;
        end
      end
      ST_LOCKED: begin
        if (atBoundary) begin
          strobe.seedLoad = 1'b1;
          if (syncSeen) begin
            missN = 1'b0;
            stopN = 1'b1;
          end else if (missOnce) begin
            stateN = ST_HUNT;
            missN  = 1'b0;
          end else begin
            missN = 1'b1;
          end
        end else begin
          strobe.advance = 1'b1;
          strobe.checkEn = 1'b1;
        end
      end
      default: stateN = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_HUNT;
      nextIdx   <= '0;
      missOnce  <= 1'b0;
      stopPulse <= 1'b0;
    end else begin
      state     <= stateN;
      nextIdx   <= idxN;
      missOnce  <= missN;
      stopPulse <= stopN;
    end
  end

  assign hfSync = (state == ST_LOCKED);

  // R3
  sync_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hfSync) |-> $past(syncSeen));

  // R5
  sync_loss_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(hfSync) |-> !$past(syncSeen));

  // R10
  stop_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopPulse |-> $past(syncSeen));

endmodule

// File: rtl/hfPrbsDatapath.sv
module hfPrbsDatapath
  import hfChkPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ERR_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] rxData,
  output logic [ERR_W-1:0]  errCount,
  output logic              errSticky
);

  localparam logic [ERR_W-1:0] ERR_MAX = '1;

  logic [6:0]        lfsr;
  logic [6:0]        chain [0:DATA_W];
  logic [DATA_W-1:0] expWord;
  logic              mismatch;

  assign chain[0] = lfsr;

  // one PRBS-7 step per data bit, first bit on the MSB
  for (genvar g = 0; g < DATA_W; g++) begin : g_step
    logic newBit;
    assign newBit              = chain[g][6] ^ chain[g][5];
    assign chain[g+1]          = {chain[g][5:0], newBit};
    assign expWord[DATA_W-1-g] = newBit;
  end

  assign mismatch = strobe.checkEn && (rxData != expWord);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lfsr      <= PRBS_SEED;
      errCount  <= '0;
      errSticky <= 1'b0;
    end else begin
      if (strobe.seedLoad)     lfsr <= PRBS_SEED;
      else if (strobe.advance) lfsr <= chain[DATA_W];
      if (mismatch) begin
        errSticky <= 1'b1;
        if (errCount != ERR_MAX) errCount <= errCount + 1'b1;
      end
    end
  end

  // R8
  err_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (errCount != $past(errCount)) |-> (errCount == $past(errCount) + 1'b1));

  // R8
  err_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (errCount == ERR_MAX) |=> (errCount == ERR_MAX));

  // R9
  sticky_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    errSticky == (errCount != '0));

  // R7
  no_check_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.checkEn |=> $stable(errCount));

endmodule

// File: rtl/hfPrbsChecker.sv
module hfPrbsChecker
  import hfChkPkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int BASE_BEATS = 32,
  parameter int SIM_MODE   = 0,
  parameter int ERR_W      = 5
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [3:0]            rateSel,
  input  logic [DATA_W-1:0]     rxData,
  input  logic [DATA_W/8-1:0]   rxCtrl,
  output logic                  hfSync,
  output logic [ERR_W-1:0]      errCount,
  output logic                  errSticky,
  output logic                  stopPulse
);

  localparam int CTRL_W = DATA_W / 8;
  localparam int IDX_W  = $clog2(BASE_BEATS * MAX_RATE);

  dpStrobe_t strobe;

  // only the low-byte flag marks a sync character
  if (CTRL_W > 1) begin : g_ignHigh
    logic unusedCtrl;
    assign unusedCtrl = ^rxCtrl[CTRL_W-1:1];
  end

  hfSyncCtrl #(
    .BASE_BEATS (BASE_BEATS),
    .SIM_MODE   (SIM_MODE),
    .IDX_W      (IDX_W)
  ) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .rateSel   (rateSel),
    .lowByte   (rxData[7:0]),
    .lowFlag   (rxCtrl[0]),
    .strobe    (strobe),
    .hfSync    (hfSync),
    .stopPulse (stopPulse)
  );

  hfPrbsDatapath #(
    .DATA_W (DATA_W),
    .ERR_W  (ERR_W)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .rxData    (rxData),
    .errCount  (errCount),
    .errSticky (errSticky)
  );

endmodule

// File: tb/sim_hfPrbsChecker.sv
module sim_hfPrbsChecker;

  localparam int CLK_PERIOD = 10;
  localparam int DW         = 16;
  localparam int BASE       = 32;
  localparam int MAX_BITS   = 16 * BASE * 15;

  logic          clk = 1'b0;
  logic          rstN = 1'b1;
  logic [3:0]    rateSel = 4'd1;
  logic [DW-1:0] rxData = '0;
  logic [1:0]    rxCtrl = '0;

  logic       hfSync0, errSticky0, stopPulse0;
  logic [4:0] errCount0;
  logic       hfSync1, errSticky1, stopPulse1;
  logic [4:0] errCount1;

  hfPrbsChecker #(.DATA_W(DW), .BASE_BEATS(BASE), .SIM_MODE(0)) u0 (
    .clk(clk), .rstN(rstN), .rateSel(rateSel), .rxData(rxData), .rxCtrl(rxCtrl),
    .hfSync(hfSync0), .errCount(errCount0), .errSticky(errSticky0), .stopPulse(stopPulse0));

  hfPrbsChecker #(.DATA_W(DW), .BASE_BEATS(BASE), .SIM_MODE(1)) u1 (
    .clk(clk), .rstN(rstN), .rateSel(rateSel), .rxData(rxData), .rxCtrl(rxCtrl),
    .hfSync(hfSync1), .errCount(errCount1), .errSticky(errSticky1), .stopPulse(stopPulse1));

  always #(CLK_PERIOD/2) clk = ~clk;

  int nChecks = 0;
  int nFails  = 0;
  bit compareOn = 0;
  bit prbsBits[$];

  // behavioural reference: 0 hunt, 1 one sync seen, 2 in sync
  int mState = 0, mIdx = 0, mMiss = 0, mErr = 0;
  bit mSticky = 0, mStop = 0;

  function automatic int hfLen(int r, bit sim);
    int n;
    n = (r == 0) ? BASE : BASE * r;
    return sim ? n / 4 : n;
  endfunction

  function automatic logic [15:0] expWord(int w);
    logic [15:0] v;
    for (int j = 0; j < 16; j++) v[15-j] = prbsBits[16*w + j];
    return v;
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  always @(posedge clk or negedge rstN) begin : refModel
    bit isSync;
    int len;
    if (!rstN) begin
      mState = 0; mIdx = 0; mMiss = 0; mErr = 0; mSticky = 0; mStop = 0;
    end else begin
      isSync = rxCtrl[0] && (rxData[7:0] == 8'hBC);
      len    = hfLen(int'(rateSel), 1'b0);
      mStop  = 0;
      if (mState == 0) begin
        if (isSync) begin mState = 1; mIdx = 1; end
      end else if (mIdx == 0) begin
        if (isSync) begin mStop = 1; mMiss = 0; mState = 2; end
        else if (mState == 1 || mMiss == 1) begin mState = 0; mMiss = 0; end
        else mMiss = 1;
        mIdx = 1;
      end else begin
        if (mState == 2 && rxData != expWord(mIdx - 1)) begin
          if (mErr < 31) mErr++;
          mSticky = 1;
        end
        mIdx = (mIdx + 1 == len) ? 0 : mIdx + 1;
      end
    end
  end

  always @(negedge clk) begin
    if (compareOn) begin
      check("R3", "hfSync per cycle", int'(hfSync0), (mState == 2) ? 1 : 0);
      check("R8", "errCount per cycle", int'(errCount0), mErr);
      check("R9", "errSticky per cycle", int'(errSticky0), int'(mSticky));
      check("R10", "stopPulse per cycle", int'(stopPulse0), int'(mStop));
    end
  end

  task automatic beat(logic [15:0] d, logic [1:0] c);
    @(negedge clk);
    rxData = d;
    rxCtrl = c;
  endtask

  task automatic sendSync(logic [7:0] hi);
    beat({hi, 8'hBC}, 2'b01);
  endtask

  task automatic sendNoSync();
    beat(16'h1234, 2'b00);
  endtask

  // n data beats; the first nBad are corrupted, alternating bit 15 / bit 0
  task automatic sendData(int n, int nBad);
    logic [15:0] d;
    for (int i = 0; i < n; i++) begin
      d = expWord(i);
      if (i < nBad) d = d ^ ((i % 2 == 0) ? 16'h8000 : 16'h0001);
      beat(d, 2'b00);
    end
  endtask

  task automatic sendNoise(int n);
    for (int i = 0; i < n; i++) beat(16'($urandom), 2'b00);
  endtask

  task automatic settle();
    @(posedge clk);
    #1;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin : stimulus
    int s;
    s = 7'h7F;
    for (int i = 0; i < MAX_BITS; i++) begin
      bit nb;
      nb = ((s >> 6) & 1) ^ ((s >> 5) & 1);
      s  = ((s << 1) | int'(nb)) & 7'h7F;
      prbsBits.push_back(nb);
    end

    #1 rstN = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", "hfSync in reset", int'(hfSync0), 0);
    check("R1", "errCount in reset", int'(errCount0), 0);
    check("R1", "errSticky in reset", int'(errSticky0), 0);
    check("R1", "stopPulse in reset", int'(stopPulse0), 0);
    rstN = 1'b1;
    compareOn = 1;

    // R2: 0xBC on the wrong byte or without the low flag
    rateSel = 4'd1;
    beat(16'hBC00, 2'b10);
    beat(16'hBCBC, 2'b10);
    beat(16'h00BC, 2'b00);
    sendNoise(4);
    sendData(31, 0);
    beat(16'hBC00, 2'b10);
    settle();
    check("R2", "no sync from wrong byte", int'(hfSync0), 0);
    check("R7", "no count before sync", int'(errCount0), 0);

    // R3: one sync is not enough, second at L=32 locks
    sendSync(8'hA5);
    sendData(31, 0);
    settle();
    check("R3", "single sync", int'(hfSync0), 0);
    sendSync(8'h5A);
    settle();
    check("R3", "locked after second sync", int'(hfSync0), 1);
    check("R10", "stop on confirming sync", int'(stopPulse0), 1);
    sendData(31, 0);
    sendSync(8'h00);
    sendData(31, 0);
    settle();
    check("R6", "clean PRBS frames", int'(errCount0), 0);

    // R8/R9/R6: three corrupted beats incl. bit 15
    sendSync(8'h00);
    settle();
    check("R10", "stop while locked", int'(stopPulse0), 1);
    sendData(31, 3);
    settle();
    check("R8", "three mismatches", int'(errCount0), 3);
    check("R9", "sticky set", int'(errSticky0), 1);

    // R5: single miss tolerated, double miss drops
    sendNoSync();
    sendData(31, 0);
    settle();
    check("R5", "one miss keeps sync", int'(hfSync0), 1);
    check("R6", "reseed after missed sync", int'(errCount0), 3);
    sendSync(8'h00);
    sendData(31, 0);
    sendNoSync();
    sendData(31, 0);
    sendNoSync();
    settle();
    check("R5", "two misses drop sync", int'(hfSync0), 0);
    sendNoise(40);
    settle();
    check("R7", "noise ignored while unlocked", int'(errCount0), 3);

    // R4: rate 3 gives L=96; spacing 32 must not lock
    rateSel = 4'd3;
    sendSync(8'h00);
    sendData(31, 0);
    sendSync(8'h00);
    settle();
    check("R4", "wrong spacing at rate 3", int'(hfSync0), 0);
    sendNoise(100);
    sendSync(8'h11);
    sendData(95, 0);
    sendSync(8'h22);
    settle();
    check("R4", "lock at L=96", int'(hfSync0), 1);
    sendData(95, 35);
    sendSync(8'h00);
    settle();
    check("R8", "saturation at 31", int'(errCount0), 31);
    sendData(95, 4);
    settle();
    check("R8", "stays saturated", int'(errCount0), 31);

    // R11: asynchronous reset mid-cycle
    @(posedge clk);
    #2 rstN = 1'b0;
    #1;
    check("R11", "hfSync cleared async", int'(hfSync0), 0);
    check("R11", "errCount cleared async", int'(errCount0), 0);
    check("R11", "errSticky cleared async", int'(errSticky0), 0);
    @(negedge clk);
    rxData = '0; rxCtrl = '0;
    @(negedge clk);
    rstN = 1'b1;

    // R4: simulation mode quarter length (8 beats at rate 1)
    rateSel = 4'd1;
    sendSync(8'h00);
    sendData(7, 0);
    sendSync(8'h00);
    settle();
    check("R4", "sim-mode lock at L=8", int'(hfSync1), 1);
    check("R4", "normal mode not locked at 8", int'(hfSync0), 0);
    sendNoise(5);
    settle();

    compareOn = 0;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule